// File: doc/BRIEF.md
# PCI Host Bridge Address Decoder

This block sits on the host side of a PCI host bridge, between a processor bus and the configuration and interrupt fabric. It claims processor cycles that land in a few fixed regions and ignores the rest. A 4 MiB memory window gives direct configuration access. In that window a one-hot device-select field in the address is reduced to a binary device number by a lowest-bit-first scan. A pair of I/O ports gives conventional indirect access: an index register and a data register. A single-byte memory location performs an interrupt-acknowledge cycle against an external interrupt controller port.

Configuration accesses that reach another device go out on a simple request/acknowledge port. Accesses to the bridge's own header are answered locally. The processor side uses a valid/ready handshake, and only one request is in flight at a time. The block also routes device interrupt pins onto host interrupt lines, swizzled by slot parity.

Top module: `pci_host_decoder`

## Requirements
- R1: A memory access (req_io_i=0) with address 0x80800000..0x80BFFFFF is claimed. Address bits 11..21 are scanned from bit 11 upward. The index i is the position of the first set bit minus 11, or 11 when none of them is set. The configuration address is then address[10:0] | (i << 11).
- R2: Data is little-endian and right-justified, with the lowest-addressed byte in bits 7:0. Write data, size code and direction pass unchanged to the configuration port. Read data from that port passes unchanged to rsp_rdata_o. Size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R3: An I/O access (req_io_i=1) at 0xCF8 with size code 2 writes or reads the 32-bit index register. An I/O access at 0xCFC..0xCFF with index bit 31 set forms the configuration address {8'h00, index[23:2], address[1:0]}.
- R4: While index bit 31 is clear, a data-port read returns 0xFFFFFFFF and a data-port write completes without error. Neither makes any configuration-port request.
- R5: A configuration address whose bits 23:8 are all zero targets the bridge itself and is answered locally, with no configuration-port request. The header returns 0x08 at offset 0x0C, 0x10 at offset 0x0D and 0x00 at offset 0x34, and zero elsewhere. Writes to it are dropped.
- R6: A 1-byte memory read at 0xBFFFFFF0 raises iack_req_o until iack_ack_i. The response carries iack_vec_i in bits 7:0, with the upper bits zero.
- R7: Any of the following gets an error response with zero data and starts no request on either port: a write or wider-than-byte access at the acknowledge location, an address outside every region, a non-word access to the index port, or size code 3.
- R8: req_ready_o is high only while idle. Locally answered and error requests respond one cycle after acceptance. Forwarded requests respond one cycle after the acknowledge cycle. rsp_valid_o is a one-cycle pulse.
- R9: Device pin p of slot s (dev_irq_i bit s*4+p, device number s) drives host line (p + s) & 1. Each line is the OR of its routed pins, registered once. Lines 2 and 3 stay low.
- R10: After reset, req_ready_o is high, all request and response strobes and host lines are low, and the index register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Decoder idle and accepting |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_we_i | input | 1 | 1 = write |
| req_addr_i | input | 32 | Processor address |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 32 | Write data, right-justified |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Unclaimed or invalid access |
| rsp_rdata_o | output | 32 | Read data |
| cfg_req_o | output | 1 | Configuration request, held until ack |
| cfg_we_o | output | 1 | Configuration write |
| cfg_addr_o | output | 32 | Configuration address |
| cfg_size_o | output | 2 | Configuration size code |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_ack_i | input | 1 | Configuration completion |
| cfg_rdata_i | input | 32 | Configuration read data |
| iack_req_o | output | 1 | Interrupt-acknowledge request |
| iack_ack_i | input | 1 | Interrupt controller completion |
| iack_vec_i | input | 8 | Interrupt vector |
| dev_irq_i | input | 16 | Device pin levels, 4 per slot |
| host_irq_o | output | 4 | Host interrupt lines |

## Verification
Locally answered, disabled-port and error requests must show rsp_valid_o at the first sample after the accepting edge. Forwarded and acknowledge cycles must respond exactly one sample after the acknowledge is driven, so the bench expects a latency of one plus the programmed responder delay. The bench drives and samples on the falling edge and counts the falling edges from acceptance to the response. Each latency is compared with the value due. Interrupt routing is registered once, so each pin pattern is checked one falling edge after it is applied. Port request counters prove that local, disabled and error cases stay off the configuration and acknowledge ports.

// File: rtl/pci_hb_pkg.sv
package pci_hb_pkg;
  localparam int DATA_W  = 32;
  localparam int SCAN_LO = 11;

  localparam logic [1:0] SZ_B   = 2'd0;
  localparam logic [1:0] SZ_H   = 2'd1;
  localparam logic [1:0] SZ_W   = 2'd2;
  localparam logic [1:0] SZ_BAD = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_IACK, ST_RSP} state_e;
  typedef enum logic [1:0] {A_ERR, A_DONE, A_FWD, A_IACK} act_e;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    size_mask = 32'h0000_00FF;
      SZ_H:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pci_hb_cfg_scan.sv
module pci_hb_cfg_scan #(
  parameter int LO = 11,
  parameter int N  = 11
) (
  input  logic [LO+N-1:0] offset_i,
  output logic [31:0]     cfg_addr_o
);
  localparam int IW = $clog2(N + 1);

  logic [IW-1:0] idx;

  // lowest set bit wins
  always_comb begin
    idx = IW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (offset_i[LO+i]) idx = IW'(i);
    end
  end

  assign cfg_addr_o = 32'(offset_i[LO-1:0]) | (32'(idx) << LO);

  always_comb begin
    if (idx != IW'(N)) begin
      p_scan_lowest_r1: assert (offset_i[LO+int'(idx)] &&
        ((offset_i[LO+:N] & ((N'(1) << idx) - N'(1))) == '0))
        else $error("p_scan_lowest_r1");
    end else begin
      p_scan_none_r1: assert (offset_i[LO+:N] == '0) else $error("p_scan_none_r1");
    end
  end
endmodule

// File: rtl/pci_hb_self_hdr.sv
module pci_hb_self_hdr
  import pci_hb_pkg::*;
#(
  parameter logic [7:0] CLS = 8'h08,
  parameter logic [7:0] LAT = 8'h10,
  parameter logic [7:0] CAP = 8'h00
) (
  input  logic [7:0]        reg_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] dword;

  always_comb begin
    case (reg_i[7:2])
      6'h03:   dword = {16'h0000, LAT, CLS};
      6'h0D:   dword = {24'h000000, CAP};
      default: dword = '0;
    endcase
  end

  assign rdata_o = (dword >> {reg_i[1:0], 3'b000}) & size_mask(size_i);
endmodule

// File: rtl/pci_hb_irq_route.sv
module pci_hb_irq_route #(
  parameter int NUM_SLOTS = 4,
  parameter int PINS      = 4,
  parameter int HOST_IRQS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SLOTS*PINS-1:0] dev_irq_i,
  output logic [HOST_IRQS-1:0]      host_irq_o
);
  logic [HOST_IRQS-1:0] lvl;

  for (genvar h = 0; h < HOST_IRQS; h++) begin : g_line
    logic any;
    always_comb begin
      any = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < PINS; p++) begin
          if (((p + s) % 2) == h) any = any | dev_irq_i[s*PINS+p];
        end
      end
    end
    assign lvl[h] = any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_irq_o <= '0;
    else         host_irq_o <= lvl;
  end

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dev_irq_i) == '0) |-> (host_irq_o == '0));

  p_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_irq_o != '0) |-> ($past(dev_irq_i) != '0));
endmodule

// File: rtl/pci_host_decoder.sv
module pci_host_decoder
  import pci_hb_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
  parameter int          WIN_BITS  = 22,
  parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
  parameter logic [31:0] IDX_PORT  = 32'h0000_0CF8,
  parameter logic [31:0] DAT_PORT  = 32'h0000_0CFC,
  parameter int          NUM_SLOTS = 4,
  parameter int          PINS      = 4,
  parameter int          HOST_IRQS = 4,
  parameter int          VEC_W     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_io_i,
  input  logic                      req_we_i,
  input  logic [31:0]               req_addr_i,
  input  logic [1:0]                req_size_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_err_o,
  output logic [DATA_W-1:0]         rsp_rdata_o,
  output logic                      cfg_req_o,
  output logic                      cfg_we_o,
  output logic [31:0]               cfg_addr_o,
  output logic [1:0]                cfg_size_o,
  output logic [DATA_W-1:0]         cfg_wdata_o,
  input  logic                      cfg_ack_i,
  input  logic [DATA_W-1:0]         cfg_rdata_i,
  output logic                      iack_req_o,
  input  logic                      iack_ack_i,
  input  logic [VEC_W-1:0]          iack_vec_i,
  input  logic [NUM_SLOTS*PINS-1:0] dev_irq_i,
  output logic [HOST_IRQS-1:0]      host_irq_o
);
  localparam int SCAN_N = WIN_BITS - SCAN_LO;

  state_e            state_q;
  logic [31:0]       index_q;
  logic [31:0]       cfg_addr_q;
  logic              cfg_we_q;
  logic [1:0]        cfg_size_q;
  logic [DATA_W-1:0] cfg_wdata_q;
  logic              rsp_err_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic              is_win, is_iack, is_idx, is_dat;
  logic [31:0]       direct_addr, indirect_addr, sel_cfg;
  logic [DATA_W-1:0] hdr_rdata, loc_rdata;
  logic              idx_wr;
  act_e              act;

  assign is_win  = !req_io_i && (req_addr_i[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
  assign is_iack = !req_io_i && (req_addr_i == IACK_ADDR);
  assign is_idx  = req_io_i && (req_addr_i == IDX_PORT);
  assign is_dat  = req_io_i && (req_addr_i[31:2] == DAT_PORT[31:2]);

  pci_hb_cfg_scan #(.LO(SCAN_LO), .N(SCAN_N)) u_scan (
    .offset_i   (req_addr_i[WIN_BITS-1:0]),
    .cfg_addr_o (direct_addr)
  );

  assign indirect_addr = {8'h00, index_q[23:2], req_addr_i[1:0]};
  assign sel_cfg       = is_win ? direct_addr : indirect_addr;

  pci_hb_self_hdr u_hdr (
    .reg_i   (sel_cfg[7:0]),
    .size_i  (req_size_i),
    .rdata_o (hdr_rdata)
  );

  always_comb begin
    act       = A_ERR;
    loc_rdata = '0;
    idx_wr    = 1'b0;
    if (req_size_i == SZ_BAD) begin
      act = A_ERR;
    end else if (is_iack) begin
      act = (!req_we_i && req_size_i == SZ_B) ? A_IACK : A_ERR;
    end else if (is_idx) begin
      if (req_size_i == SZ_W) begin
        act = A_DONE;
        if (req_we_i) idx_wr = 1'b1;
        else          loc_rdata = index_q;
      end
    end else if (is_win || is_dat) begin
      if (is_dat && !index_q[31]) begin
        act       = A_DONE;
        loc_rdata = req_we_i ? '0 : '1;
      end else if (sel_cfg[23:8] == '0) begin
        act       = A_DONE;
        loc_rdata = req_we_i ? '0 : hdr_rdata;
      end else begin
        act = A_FWD;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      index_q     <= '0;
      cfg_addr_q  <= '0;
      cfg_we_q    <= 1'b0;
      cfg_size_q  <= '0;
      cfg_wdata_q <= '0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          cfg_addr_q  <= sel_cfg;
          cfg_we_q    <= req_we_i;
          cfg_size_q  <= req_size_i;
          cfg_wdata_q <= req_wdata_i;
          rsp_err_q   <= (act == A_ERR);
          rsp_rdata_q <= loc_rdata;
          if (idx_wr) index_q <= req_wdata_i;
          case (act)
            A_FWD:   state_q <= ST_CFG;
            A_IACK:  state_q <= ST_IACK;
            default: state_q <= ST_RSP;
          endcase
        end
        ST_CFG: if (cfg_ack_i) begin
          rsp_rdata_q <= cfg_we_q ? '0 : cfg_rdata_i;
          state_q     <= ST_RSP;
        end
        ST_IACK: if (iack_ack_i) begin
          rsp_rdata_q <= DATA_W'(iack_vec_i);
          state_q     <= ST_RSP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cfg_req_o   = (state_q == ST_CFG);
  assign iack_req_o  = (state_q == ST_IACK);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_err_o   = rsp_valid_o && rsp_err_q;
  assign rsp_rdata_o = rsp_valid_o ? rsp_rdata_q : '0;
  assign cfg_we_o    = cfg_we_q;
  assign cfg_addr_o  = cfg_addr_q;
  assign cfg_size_o  = cfg_size_q;
  assign cfg_wdata_o = cfg_wdata_q;

  pci_hb_irq_route #(.NUM_SLOTS(NUM_SLOTS), .PINS(PINS), .HOST_IRQS(HOST_IRQS)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_irq_i  (dev_irq_i),
    .host_irq_o (host_irq_o)
  );

  p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o || iack_req_o || rsp_valid_o) |-> !req_ready_o);

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && !cfg_ack_i) |=> (cfg_req_o && $stable(cfg_addr_o) && $stable(cfg_wdata_o)));

  p_one_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_req_o, iack_req_o, rsp_valid_o}));

  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  p_iack_vec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_req_o && iack_ack_i) |=> (rsp_valid_o && !rsp_err_o &&
      rsp_rdata_o == DATA_W'($past(iack_vec_i))));

  p_err_direct_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> ($past(req_ready_o) && rsp_rdata_o == '0));
endmodule

// File: tb/sim_pci_host_decoder.sv
`timescale 1ns/1ps
module sim_pci_host_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_io = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid, rsp_err, req_ready;
  logic [31:0] rsp_rdata;
  logic        cfg_req, cfg_we, cfg_ack = 1'b0;
  logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = '0;
  logic [1:0]  cfg_size;
  logic        iack_req, iack_ack = 1'b0;
  logic [7:0]  iack_vec = 8'h2C;
  logic [15:0] dev_irq = '0;
  logic [3:0]  host_irq;

  always #2.5 clk = ~clk;

  pci_host_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_io_i(req_io), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr), .cfg_size_o(cfg_size),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata),
    .iack_req_o(iack_req), .iack_ack_i(iack_ack), .iack_vec_i(iack_vec),
    .dev_irq_i(dev_irq), .host_irq_o(host_irq)
  );

  int n_chk = 0, n_fail = 0;
  int cfg_delay = 0, iack_delay = 0, cfg_cnt = 0, iack_cnt = 0, cwait = 0, iwait = 0;
  logic [31:0] m_addr, m_wdata;
  logic        m_we;
  logic [1:0]  m_size;
  logic [31:0] x_rd;
  logic        x_err, x_rdy_busy;
  int          x_lat;

  // downstream responders
  always @(negedge clk) begin
    cfg_ack  = 1'b0;
    iack_ack = 1'b0;
    if (cfg_req) begin
      if (cwait == cfg_delay) begin
        cfg_ack = 1'b1; cfg_rdata = cfg_addr ^ 32'h5A5A_0000; cwait = 0; cfg_cnt++;
        m_addr = cfg_addr; m_we = cfg_we; m_wdata = cfg_wdata; m_size = cfg_size;
      end else cwait++;
    end
    if (iack_req) begin
      if (iwait == iack_delay) begin iack_ack = 1'b1; iwait = 0; iack_cnt++; end
      else iwait++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic io, input logic we, input logic [31:0] a,
                      input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_io = io; req_we = we; req_addr = a; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    x_lat = 0; x_rdy_busy = 1'b0;
    while (!rsp_valid && x_lat < 40) begin
      if (req_ready) x_rdy_busy = 1'b1;
      @(negedge clk);
      x_lat++;
    end
    x_rd = rsp_rdata; x_err = rsp_err;
  endtask

  function automatic logic [31:0] exp_direct(input logic [31:0] a);
    int k = 11;
    for (int i = 10; i >= 0; i--) if (a[11+i]) k = i;
    return {21'd0, a[10:0]} | (32'(k) << 11);
  endfunction

  function automatic logic [3:0] exp_irq(input logic [15:0] v);
    logic [3:0] r = '0;
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 4; p++)
        if (v[s*4+p]) r[(p+s)&1] = 1'b1;
    return r;
  endfunction

  task automatic t_reset;
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    chk("R10 strobes", {28'd0, rsp_valid, cfg_req, iack_req, rsp_err}, 32'd0);
    chk("R10 host_irq", {28'd0, host_irq}, 32'd0);
    xfer(1'b1, 1'b0, 32'h0CF8, 2'd2, '0);
    chk("R10 index", x_rd, 32'd0);
  endtask

  task automatic t_direct_read(input logic [31:0] a, input logic [1:0] sz, input int d);
    int c0 = cfg_cnt;
    logic [31:0] e = exp_direct(a);
    cfg_delay = d;
    xfer(1'b0, 1'b0, a, sz, '0);
    chk("R1 cfg addr", m_addr, e);
    chk("R1 forwarded", 32'(cfg_cnt - c0), 32'd1);
    chk("R2 size", {30'd0, m_size}, {30'd0, sz});
    chk("R2 rdata", x_rd, e ^ 32'h5A5A_0000);
    chk("R8 latency", 32'(x_lat), 32'(1 + d));
    chk("R8 ready low while busy", {31'd0, x_rdy_busy}, 32'd0);
  endtask

  task automatic t_direct_write;
    cfg_delay = 2;
    xfer(1'b0, 1'b1, 32'h8080_4000 | 32'h0A6, 2'd1, 32'h0000_BEEF);
    chk("R2 we", {31'd0, m_we}, 32'd1);
    chk("R2 wdata", m_wdata, 32'h0000_BEEF);
    chk("R1 write addr", m_addr, 32'h0000_18A6);
    chk("R2 write rsp", {x_rd[30:0], x_err}, 32'd0);
    chk("R8 write latency", 32'(x_lat), 32'd3);
  endtask

  task automatic t_indirect;
    int c0;
    xfer(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'h8001_2A10);
    chk("R3 index write rsp", {31'd0, x_err}, 32'd0);
    xfer(1'b1, 1'b0, 32'h0CF8, 2'd2, '0);
    chk("R3 index readback", x_rd, 32'h8001_2A10);
    cfg_delay = 1; c0 = cfg_cnt;
    xfer(1'b1, 1'b0, 32'h0CFE, 2'd0, '0);
    chk("R3 indirect addr", m_addr, 32'h0001_2A12);
    chk("R3 forwarded", 32'(cfg_cnt - c0), 32'd1);
    chk("R3 rdata", x_rd, 32'h0001_2A12 ^ 32'h5A5A_0000);
    xfer(1'b1, 1'b0, 32'h0CF8, 2'd0, '0);
    chk("R7 narrow index err", {31'd0, x_err}, 32'd1);
  endtask

  task automatic t_disabled;
    int c0 = cfg_cnt;
    xfer(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'h0001_2A10);
    xfer(1'b1, 1'b0, 32'h0CFC, 2'd2, '0);
    chk("R4 disabled read", x_rd, 32'hFFFF_FFFF);
    chk("R4 disabled latency", 32'(x_lat), 32'd0);
    xfer(1'b1, 1'b1, 32'h0CFC, 2'd2, 32'h1234_5678);
    chk("R4 disabled write ok", {31'd0, x_err}, 32'd0);
    chk("R4 no cfg request", 32'(cfg_cnt - c0), 32'd0);
  endtask

  task automatic t_header;
    int c0 = cfg_cnt;
    xfer(1'b0, 1'b0, 32'h8080_080C, 2'd0, '0);
    chk("R5 cache line", x_rd, 32'h08);
    chk("R8 local latency", 32'(x_lat), 32'd0);
    xfer(1'b0, 1'b0, 32'h8080_080D, 2'd0, '0);
    chk("R5 latency timer", x_rd, 32'h10);
    xfer(1'b0, 1'b0, 32'h8080_080C, 2'd2, '0);
    chk("R5 dword 0x0C", x_rd, 32'h0000_1008);
    xfer(1'b0, 1'b0, 32'h8080_0834, 2'd2, '0);
    chk("R5 cap ptr", x_rd, 32'h0);
    xfer(1'b0, 1'b1, 32'h8080_080C, 2'd0, 32'hFF);
    xfer(1'b0, 1'b0, 32'h8080_080C, 2'd0, '0);
    chk("R5 write dropped", x_rd, 32'h08);
    xfer(1'b1, 1'b1, 32'h0CF8, 2'd2, 32'h8000_000C);
    xfer(1'b1, 1'b0, 32'h0CFD, 2'd0, '0);
    chk("R5 indirect self", x_rd, 32'h10);
    chk("R5 no cfg request", 32'(cfg_cnt - c0), 32'd0);
  endtask

  task automatic t_iack;
    int i0 = iack_cnt;
    iack_delay = 2; iack_vec = 8'h2C;
    xfer(1'b0, 1'b0, 32'hBFFF_FFF0, 2'd0, '0);
    chk("R6 vector", x_rd, 32'h0000_002C);
    chk("R6 latency", 32'(x_lat), 32'd3);
    chk("R6 one iack", 32'(iack_cnt - i0), 32'd1);
    iack_delay = 0; iack_vec = 8'hF3;
    xfer(1'b0, 1'b0, 32'hBFFF_FFF0, 2'd0, '0);
    chk("R6 vector 2", x_rd, 32'h0000_00F3);
    i0 = iack_cnt;
    xfer(1'b0, 1'b0, 32'hBFFF_FFF0, 2'd2, '0);
    chk("R7 wide iack err", {x_rd[30:0], x_err}, 32'd1);
    xfer(1'b0, 1'b1, 32'hBFFF_FFF0, 2'd0, 32'h55);
    chk("R7 iack write err", {31'd0, x_err}, 32'd1);
    chk("R7 no iack request", 32'(iack_cnt - i0), 32'd0);
  endtask

  task automatic t_errors;
    int c0 = cfg_cnt;
    xfer(1'b0, 1'b0, 32'h1000_0000, 2'd2, '0);
    chk("R7 unmapped err", {x_rd[30:0], x_err}, 32'd1);
    chk("R7 err latency", 32'(x_lat), 32'd0);
    xfer(1'b1, 1'b0, 32'h0000_03F8, 2'd0, '0);
    chk("R7 unmapped io err", {31'd0, x_err}, 32'd1);
    xfer(1'b0, 1'b0, 32'h8088_0000, 2'd3, '0);
    chk("R7 size3 err", {31'd0, x_err}, 32'd1);
    xfer(1'b0, 1'b0, 32'h80C0_0000, 2'd2, '0);
    chk("R7 past window err", {31'd0, x_err}, 32'd1);
    chk("R7 no cfg request", 32'(cfg_cnt - c0), 32'd0);
  endtask

  task automatic t_irq;
    logic [15:0] pats [8] = '{16'h0001, 16'h0002, 16'h0010, 16'h0020,
                              16'h8000, 16'h4000, 16'hFFFF, 16'h0000};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      dev_irq = pats[k];
      @(negedge clk);
      chk($sformatf("R9 irq pattern %h", pats[k]), {28'd0, host_irq}, {28'd0, exp_irq(pats[k])});
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_read(32'h8080_0000 | 32'h4000 | 32'h123, 2'd2, 0);
    t_direct_read(32'h8080_0045, 2'd0, 3);
    t_direct_read(32'h8080_0000 | 32'h0010_0000 | 32'h2000 | 32'h7F0, 2'd1, 1);
    t_direct_read(32'h8080_0000 | 32'h0020_0000 | 32'h004, 2'd2, 0);
    t_direct_write();
    t_indirect();
    t_disabled();
    t_header();
    t_iack();
    t_errors();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule